// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a serial bit stream and samples one bit on every rising clock edge. It raises its output when the four most recent bits, oldest first, read either 1001 or 1111. Matches may overlap. The last 1 of one hit can start the next 1001. A run of ones keeps producing 1111 hits on every edge after the fourth 1.

Both patterns are tracked by one merged eight-state machine. The output is decoded from the state register alone, so it is Moore style: a match completed by the bit sampled at edge k appears on the output for the clock cycle that follows edge k. The state register is built from toggle flip-flops. The toggle input of each bit is the exclusive-or of its present value and its wanted next value. A synchronous active-high reset returns the machine to its empty-history state.

Top module: `seqdet_dual`

## Requirements
- R1: While reset is sampled high at a clock edge, the machine enters the empty-history state, and the output is 0 in the cycle after that edge.
- R2: The output is 1 in the cycle after edge k when the bits sampled at edges k-3, k-2, k-1 and k are 1, 0, 0, 1.
- R3: The output is 1 in the cycle after edge k when the bits sampled at edges k-3 through k are all 1.
- R4: In every other case the output is 0. In particular, it is 0 in the cycle after any edge that sampled a 0.
- R5: A run of N ones, with N of four or more, gives N-3 consecutive cycles of output 1.
- R6: Overlapping hits are reported. In 1001001, the shared middle 1 gives two hits three cycles apart. In 1111001, the last 1 of the run starts a 1001 hit.
- R7: For the input stream 0 1 0 1 1 1 1 0 0 1 1 0 0 1 1 1 1 1 0, the output in the cycle before each edge of the stream, and then after the last edge, reads 0 0 0 0 0 0 0 1 0 0 1 0 0 0 1 0 0 1 1.
- R8: Each state bit toggles at an edge exactly when its toggle input is 1, and holds its value otherwise.
- R9: Bits sampled before a reset never contribute to a later hit. No hit is reported until four bits have been sampled after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| w | input | 1 | Serial data bit, sampled on each rising edge |
| z | output | 1 | High for one cycle per completed 1001 or 1111 match |

## Verification
The hardest case to reach is the hand-off between the two patterns inside the merged machine. One example is a 1111 run that ends with 001, where the 1001 must reuse the run's last 1. Another is a 1001 hit followed directly by further ones, where the machine must fall back to the two-ones prefix and not the one-one prefix. Directed tasks build these streams bit by bit. A long random stream then visits every transition many times, and each output is compared against a four-bit history model.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int unsigned ST_W = 3;

    // Bits 2 and 1 both high mark the two hit states; the output decode relies on it.
    typedef enum logic [ST_W-1:0] {
        ST_EMPTY = 3'd0,  // no useful suffix
        ST_P1    = 3'd1,  // ...1 (single trailing one)
        ST_P10   = 3'd2,  // ...10
        ST_P100  = 3'd3,  // ...100
        ST_P11   = 3'd4,  // ...11
        ST_P111  = 3'd5,  // ...111
        ST_HITA  = 3'd6,  // ...1001 just completed
        ST_HITB  = 3'd7   // ...1111 just completed
    } seq_state_e;

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  seq_state_e state_q,
    input  logic       w,
    output seq_state_e state_d
);

    always_comb begin
        state_d = ST_EMPTY;
        unique case (state_q)
            ST_EMPTY: state_d = w ? ST_P1   : ST_EMPTY;
            ST_P1:    state_d = w ? ST_P11  : ST_P10;
            ST_P10:   state_d = w ? ST_P1   : ST_P100;
            ST_P100:  state_d = w ? ST_HITA : ST_EMPTY;
            ST_P11:   state_d = w ? ST_P111 : ST_P10;
            ST_P111:  state_d = w ? ST_HITB : ST_P10;
            ST_HITA:  state_d = w ? ST_P11  : ST_P10;
            ST_HITB:  state_d = w ? ST_HITB : ST_P10;
            default:  state_d = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/seqdet_treg.sv
module seqdet_treg #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] nxt_d,
    output logic [W-1:0] bits_q
);

    logic [W-1:0] tog_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign tog_d[i] = bits_q[i] ^ nxt_d[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[i] <= 1'b0;
            end else if (tog_d[i]) begin
                bits_q[i] <= ~bits_q[i];
            end
        end

        // R8
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !tog_d[i] |=> $stable(bits_q[i]));

        // R8
        flip_when_set_chk: assert property (@(posedge clk) disable iff (rst)
            tog_d[i] |=> (bits_q[i] != $past(bits_q[i])));
    end

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic w,
    output logic z
);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [ST_W-1:0]   bits_q;

    seqdet_next u_next (
        .state_q (state_q),
        .w       (w),
        .state_d (state_d)
    );

    seqdet_treg #(.W(ST_W)) u_treg (
        .clk    (clk),
        .rst    (rst),
        .nxt_d  (state_d),
        .bits_q (bits_q)
    );

    assign state_q = seq_state_e'(bits_q);
    assign z       = bits_q[2] & bits_q[1];

    // R2
    hit_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_P100 && w) |=> z);

    // R3
    hit_b_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_P111 && w) |=> z);

    // R4
    zero_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        !w |=> !z);

    // R5
    run_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HITB && w) |=> z);

    // R6
    reuse_one_chk: assert property (@(posedge clk) disable iff (rst)
        (z && w) |=> (state_q == ST_P11 || state_q == ST_HITB));

endmodule

// File: tb/seqdet_dual_tb.sv
`timescale 1ns/1ps
module seqdet_dual_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic w   = 1'b0;
    logic z;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [3:0]  hist   = 4'b0;
    int unsigned seen   = 0;

    always #2 clk = ~clk;

    seqdet_dual u_dut (
        .clk (clk),
        .rst (rst),
        .w   (w),
        .z   (z)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: z=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_z();
        return (seen >= 4) && (hist == 4'b1001 || hist == 4'b1111);
    endfunction

    // Called at a negedge; returns at the following negedge after checking z.
    task automatic push(input logic b, input string req);
        w = b;
        @(posedge clk);
        hist = {hist[2:0], b};
        seen++;
        @(negedge clk);
        check(req, z, model_z());
    endtask

    task automatic push_exp(input logic b, input logic exp, input string req);
        push(b, req);
        check(req, z, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist = 4'b0;
        seen = 0;
        check("R1", z, 1'b0);
    endtask

    task automatic t_trace();
        logic [18:0] wv = 19'b0101111001100111110;
        logic [18:0] zv = 19'b0000000100100010011;
        do_reset();
        check("R7", z, zv[18]);
        for (int i = 18; i >= 0; i--) begin
            push(wv[i], "R7");
            if (i > 0) check("R7", z, zv[i-1]);
        end
    endtask

    task automatic t_pattern_a();
        do_reset();
        push_exp(1, 0, "R4"); push_exp(0, 0, "R4");
        push_exp(0, 0, "R4"); push_exp(1, 1, "R2");
        push_exp(0, 0, "R4");
    endtask

    task automatic t_run_ones();
        do_reset();
        push_exp(1, 0, "R9"); push_exp(1, 0, "R9"); push_exp(1, 0, "R9");
        push_exp(1, 1, "R3");
        push_exp(1, 1, "R5"); push_exp(1, 1, "R5");
        push_exp(0, 0, "R4");
    endtask

    task automatic t_overlap();
        do_reset();
        // 1001001 : hits at bit 4 and bit 7
        push_exp(1, 0, "R6"); push_exp(0, 0, "R6"); push_exp(0, 0, "R6");
        push_exp(1, 1, "R6"); push_exp(0, 0, "R6"); push_exp(0, 0, "R6");
        push_exp(1, 1, "R6");
        // hit then ones: 1001 followed by 11 -> 1111 needs two more ones
        push_exp(1, 0, "R6"); push_exp(1, 0, "R6"); push_exp(1, 1, "R6");
        // 1111 then 001 reuses the last one
        push_exp(0, 0, "R6"); push_exp(0, 0, "R6"); push_exp(1, 1, "R6");
    endtask

    task automatic t_mid_reset();
        do_reset();
        push(1, "R9"); push(0, "R9"); push(0, "R9");
        do_reset();
        push_exp(1, 0, "R9");
        push(1, "R9"); push(1, "R9");
        do_reset();
        push_exp(1, 0, "R9"); push_exp(1, 0, "R9");
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            push(1'($urandom_range(0, 1)), "R4");
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_trace();
        t_pattern_a();
        t_run_ones();
        t_overlap();
        t_mid_reset();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule